// File: doc/BRIEF.md
# Manchester Preamble Receiver

This block is the front end of a Manchester serial receiver. It watches a line that has already been synchronised to the system clock and is sampled on a 16x oversampling enable. It splits the line into half-bit pairs and decodes each valid pair to a data bit. Decoded bits are held back until a configured preamble has been seen. After that, every further bit is handed on as a one-cycle strobe, so that the next stage can start capturing data.

Three configuration inputs control the receiver: a preamble length from 0 to 15 bits, a two-bit pattern code and a polarity bit. The half-bit sampling counter is pulled back into line on each transition near the expected mid-bit point. This lets the receiver follow a line whose bit period is a little long or a little short. A pair of equal half-bits is a coding violation. It raises an error pulse, drops the bit alignment and starts the preamble search again. The same event marks the end of a frame when the line goes idle.

Top module: `mrx_preamble_rx`

## Requirements
- R1: While reset is held and right after it is released, `pre_found`, `bit_valid`, `bit_data` and `code_err` are all low.
- R2: With `cfg_rx_pol` = 0, a low first half followed by a high second half decodes as 0, and high-then-low decodes as 1. With `cfg_rx_pol` = 1 both mappings are inverted.
- R3: When `cfg_pre_len` = 0, `pre_found` never pulses, and every valid symbol from the first one is delivered as data.
- R4: When `cfg_pre_len` = N (1 to 15), `pre_found` pulses for one cycle once N consecutive decoded bits have matched the pattern. Those N bits are not delivered, and the bits that follow are delivered.
- R5: Pattern codes (`cfg_pre_pat`): 2'b00 expects all ones, 2'b01 expects all zeros, 2'b10 expects 0,1,0,1,... starting with 0, and 2'b11 expects 1,0,1,0,... starting with 1.
- R6: A decoded bit that does not match the expected pattern bit clears the match count to zero, and that bit does not count as a new first match.
- R7: Two equal half-bits raise `code_err` for exactly one cycle, drop bit alignment and restart the preamble search from a count of zero. The next line transition is then taken as a mid-bit transition.
- R8: After detection, each decoded bit appears on `bit_data` together with a one-cycle `bit_valid` pulse, in arrival order (the first bit delivered is the LSB of a word). `bit_valid` and `pre_found` are never high in the same cycle.
- R9: The line is looked at only on cycles where `os_tick` is high. A transition within 3 ticks of the expected mid-bit point realigns the half-bit counter, so half-bit lengths of 7 to 9 ticks decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 ticks per bit period |
| line_in | input | 1 | Synchronised serial line sample |
| cfg_pre_len | input | LEN_W | Preamble length in bits; 0 bypasses the search |
| cfg_pre_pat | input | 2 | Preamble pattern code |
| cfg_rx_pol | input | 1 | Manchester polarity select |
| pre_found | output | 1 | One-cycle pulse when the preamble is complete |
| bit_valid | output | 1 | One-cycle strobe for each delivered data bit |
| bit_data | output | 1 | Delivered data bit, valid with `bit_valid` |
| code_err | output | 1 | One-cycle pulse on an invalid symbol |

## Verification
The hardest conditions to reach from the ports are a line whose bit period drifts away from sixteen ticks, and a coding violation that arrives partway through a preamble. Drift only shows up as failures if realignment is broken. A violation only matters if the partial match count survives it. The stimulus covers drift with frames whose half-bits last 7 and 9 ticks. It covers the violation by inserting a symbol with two equal halves after two matching preamble bits. It then sends one bit fewer than the preamble length, so that a leftover count would produce a detection that should not occur.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [1:0] {
    PAT_ONES  = 2'b00,
    PAT_ZEROS = 2'b01,
    PAT_ZO    = 2'b10,
    PAT_OZ    = 2'b11
  } pat_e;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_DATA   = 1'b1
  } rx_state_e;

  // expected preamble bit at a position with the given parity
  function automatic logic pat_bit(input pat_e pat, input logic odd_pos);
    case (pat)
      PAT_ONES:  pat_bit = 1'b1;
      PAT_ZEROS: pat_bit = 1'b0;
      PAT_ZO:    pat_bit = odd_pos;
      default:   pat_bit = ~odd_pos;
    endcase
  endfunction

  // first half-bit level and polarity give the decoded bit
  function automatic logic sym_to_bit(input logic first_half, input logic pol);
    sym_to_bit = first_half ^ pol;
  endfunction

endpackage

// File: rtl/mrx_half_sampler.sv
module mrx_half_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  output logic sym_stb,
  output logic sym_bad,
  output logic sym_first
);
  localparam int PW  = $clog2(OSR);
  localparam int WIN = OSR / 4 - 1;
  localparam logic [PW-1:0] SEC_PH = PW'(OSR / 4);
  localparam logic [PW-1:0] FIR_PH = PW'(3 * OSR / 4);
  localparam logic [PW-1:0] WIN_HI = PW'(OSR - 1 - WIN);
  localparam logic [PW-1:0] WIN_LO = PW'(WIN - 1);

  logic          line_q;
  logic          locked;
  logic [PW-1:0] phase;
  logic          first_h;
  logic          edge_seen;
  logic          realign;
  logic          at_second;
  logic          at_first;

  function automatic logic near_mid(input logic [PW-1:0] p);
    near_mid = (p >= WIN_HI) || (p <= WIN_LO);
  endfunction

  always_comb begin
    edge_seen = tick && (line != line_q);
    realign   = locked && edge_seen && near_mid(phase);
    at_second = tick && locked && (phase == SEC_PH);
    at_first  = tick && locked && (phase == FIR_PH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= 1'b0;
      locked    <= 1'b0;
      phase     <= '0;
      first_h   <= 1'b0;
      sym_stb   <= 1'b0;
      sym_bad   <= 1'b0;
      sym_first <= 1'b0;
    end else begin
      sym_stb <= 1'b0;
      sym_bad <= 1'b0;
      if (tick) line_q <= line;
      if (!locked) begin
        if (edge_seen) begin
          locked  <= 1'b1;
          phase   <= '0;
          first_h <= line_q;
        end
      end else begin
        if (tick) phase <= realign ? '0 : phase + 1'b1;
        if (at_second) begin
          if (line == first_h) begin
            sym_bad <= 1'b1;
            locked  <= 1'b0;
          end else begin
            sym_stb   <= 1'b1;
            sym_first <= first_h;
          end
        end
        if (at_first) first_h <= line;
      end
    end
  end

endmodule

// File: rtl/mrx_preamble_fsm.sv
module mrx_preamble_fsm
  import mrx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_stb,
  input  logic             sym_bad,
  input  logic             sym_bit,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_pat,
  output logic             pre_found,
  output logic             bit_valid,
  output logic             bit_data,
  output logic [LEN_W-1:0] match_cnt
);
  rx_state_e state;
  logic      expect_bit;
  logic      last_match;

  always_comb begin
    expect_bit = pat_bit(pat_e'(cfg_pat), match_cnt[0]);
    last_match = ({1'b0, match_cnt} + 1'b1) == {1'b0, cfg_len};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_SEARCH;
      match_cnt <= '0;
      pre_found <= 1'b0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      pre_found <= 1'b0;
      bit_valid <= 1'b0;
      if (sym_bad) begin
        state     <= ST_SEARCH;
        match_cnt <= '0;
      end else if (sym_stb) begin
        case (state)
          ST_SEARCH: begin
            if (cfg_len == '0) begin
              state     <= ST_DATA;
              bit_valid <= 1'b1;
              bit_data  <= sym_bit;
            end else if (sym_bit == expect_bit) begin
              if (last_match) begin
                pre_found <= 1'b1;
                state     <= ST_DATA;
                match_cnt <= '0;
              end else begin
                match_cnt <= match_cnt + 1'b1;
              end
            end else begin
              match_cnt <= '0;
            end
          end
          default: begin
            bit_valid <= 1'b1;
            bit_data  <= sym_bit;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/mrx_preamble_rx.sv
module mrx_preamble_rx
  import mrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             line_in,
  input  logic [LEN_W-1:0] cfg_pre_len,
  input  logic [1:0]       cfg_pre_pat,
  input  logic             cfg_rx_pol,
  output logic             pre_found,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             code_err
);
  logic             sym_stb;
  logic             sym_bad;
  logic             sym_first;
  logic             sym_bit;
  logic [LEN_W-1:0] match_cnt;

  mrx_half_sampler #(.OSR(OSR)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .line      (line_in),
    .sym_stb   (sym_stb),
    .sym_bad   (sym_bad),
    .sym_first (sym_first)
  );

  assign sym_bit = sym_to_bit(sym_first, cfg_rx_pol);

  mrx_preamble_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (sym_stb),
    .sym_bad   (sym_bad),
    .sym_bit   (sym_bit),
    .cfg_len   (cfg_pre_len),
    .cfg_pat   (cfg_pre_pat),
    .pre_found (pre_found),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .match_cnt (match_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) code_err <= 1'b0;
    else        code_err <= sym_bad;
  end

endmodule

// File: rtl/mrx_preamble_rx_chk.sv
module mrx_preamble_rx_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             os_tick,
  input logic [LEN_W-1:0] cfg_pre_len,
  input logic             pre_found,
  input logic             bit_valid,
  input logic             code_err,
  input logic             sym_stb,
  input logic [LEN_W-1:0] match_cnt
);
  // R4
  pre_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_found |=> !pre_found);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> !code_err);

  // R8
  found_vs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_found && bit_valid));

  // R8
  bit_from_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(sym_stb));

  // R9
  sym_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> $past(os_tick));

  // R3
  no_found_len0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_pre_len == '0) && $stable(cfg_pre_len)) |-> !pre_found);

  // R6
  count_below_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_pre_len != '0) && $stable(cfg_pre_len)) |-> (match_cnt < cfg_pre_len));

endmodule

bind mrx_preamble_rx mrx_preamble_rx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .os_tick     (os_tick),
  .cfg_pre_len (cfg_pre_len),
  .pre_found   (pre_found),
  .bit_valid   (bit_valid),
  .code_err    (code_err),
  .sym_stb     (sym_stb),
  .match_cnt   (match_cnt)
);

// File: tb/mrx_preamble_rx_test.sv
module mrx_preamble_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_NOM   = 16;

  typedef struct packed {
    logic [3:0] len;
    logic [1:0] pat;
    logic       pol;
    logic [4:0] npre;
    logic [7:0] data;
    logic       found;
    logic [3:0] nb;
    logic [7:0] wexp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    {4'd4,  2'd0, 1'b0, 5'd4,  8'hA5, 1'b1, 4'd8, 8'hA5},
    {4'd4,  2'd1, 1'b0, 5'd4,  8'h3C, 1'b1, 4'd8, 8'h3C},
    {4'd6,  2'd2, 1'b1, 5'd6,  8'h96, 1'b1, 4'd8, 8'h96},
    {4'd5,  2'd3, 1'b1, 5'd5,  8'h0F, 1'b1, 4'd8, 8'h0F},
    {4'd0,  2'd0, 1'b0, 5'd0,  8'h5A, 1'b0, 4'd8, 8'h5A},
    {4'd15, 2'd0, 1'b0, 5'd15, 8'hC3, 1'b1, 4'd8, 8'hC3},
    {4'd8,  2'd2, 1'b0, 5'd3,  8'h00, 1'b0, 4'd0, 8'h00},
    {4'd1,  2'd1, 1'b1, 5'd1,  8'hFF, 1'b1, 4'd8, 8'hFF},
    {4'd6,  2'd0, 1'b0, 5'd3,  8'hFE, 1'b1, 4'd1, 8'h01}
  };

  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic       line_in;
  logic [3:0] cfg_len;
  logic [1:0] cfg_pat;
  logic       cfg_pol;
  logic       pre_found;
  logic       bit_valid;
  logic       bit_data;
  logic       code_err;

  int checks = 0;
  int fails  = 0;
  int tot_bits  = 0;
  int tot_found = 0;
  int tot_err   = 0;
  logic bit_log [0:2047];

  mrx_preamble_rx uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .os_tick     (os_tick),
    .line_in     (line_in),
    .cfg_pre_len (cfg_len),
    .cfg_pre_pat (cfg_pat),
    .cfg_rx_pol  (cfg_pol),
    .pre_found   (pre_found),
    .bit_valid   (bit_valid),
    .bit_data    (bit_data),
    .code_err    (code_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    os_tick = 1'b0;
    forever begin
      @(negedge clk);
      os_tick = ~os_tick;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (tot_bits < 2048) bit_log[tot_bits] = bit_data;
        tot_bits++;
      end
      if (pre_found) tot_found++;
      if (code_err) tot_err++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pat_expect(input logic [1:0] pat, input int k);
    case (pat)
      2'd0:    pat_expect = 1'b1;
      2'd1:    pat_expect = 1'b0;
      2'd2:    pat_expect = (k % 2) == 1;
      default: pat_expect = (k % 2) == 0;
    endcase
  endfunction

  task automatic run_halves(input logic [3:0] len, input logic [1:0] pat,
                            input logic pol, input logic [63:0] hv, input int nh,
                            input int half_clk, output int f, output int nb,
                            output logic [7:0] w, output int e);
    int b0;
    int f0;
    int e0;
    @(negedge clk);
    cfg_len = len;
    cfg_pat = pat;
    cfg_pol = pol;
    line_in = hv[0];
    repeat (100) @(negedge clk);
    b0 = tot_bits;
    f0 = tot_found;
    e0 = tot_err;
    for (int i = 0; i < nh; i++) begin
      line_in = hv[i];
      repeat (half_clk) @(negedge clk);
    end
    repeat (100) @(negedge clk);
    f  = tot_found - f0;
    nb = tot_bits - b0;
    e  = tot_err - e0;
    w  = '0;
    for (int i = 0; i < 8; i++) if (i < nb) w[i] = bit_log[b0 + i];
  endtask

  task automatic run_frame(input logic [3:0] len, input logic [1:0] pat,
                           input logic pol, input int npre, input logic [7:0] data,
                           input int half_clk, output int f, output int nb,
                           output logic [7:0] w, output int e);
    logic [63:0] hv;
    int nh;
    logic b;
    logic fh;
    hv = '0;
    nh = 0;
    for (int k = 0; k < npre + 8; k++) begin
      b  = (k < npre) ? pat_expect(pat, k) : data[k - npre];
      fh = (pol == 1'b0) ? b : !b;
      hv[nh]     = fh;
      hv[nh + 1] = !fh;
      nh += 2;
    end
    run_halves(len, pat, pol, hv, nh, half_clk, f, nb, w, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int f;
    int nb;
    int e;
    logic [7:0] w;
    logic [63:0] hv;
    int nh;
    rst_n   = 1'b0;
    line_in = 1'b1;
    cfg_len = 4'd4;
    cfg_pat = 2'd0;
    cfg_pol = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 pre_found in reset", int'(pre_found), 0);
    chk("R1 bit_valid in reset", int'(bit_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pre_found after reset", int'(pre_found), 0);
    chk("R1 bit_valid after reset", int'(bit_valid), 0);
    chk("R1 bit_data after reset", int'(bit_data), 0);
    chk("R1 code_err after reset", int'(code_err), 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v].len, VECS[v].pat, VECS[v].pol, int'(VECS[v].npre),
                VECS[v].data, HALF_NOM, f, nb, w, e);
      chk("R3 R4 R5 found count", f, int'(VECS[v].found));
      chk("R6 R8 delivered bits", nb, int'(VECS[v].nb));
      chk("R2 R8 delivered word", int'(w), int'(VECS[v].wexp));
      chk("R7 end of frame error", e, 1);
    end

    // R9 slow line: half-bits of 9 ticks
    run_frame(4'd4, 2'd0, 1'b0, 4, 8'h6B, 18, f, nb, w, e);
    chk("R9 slow found", f, 1);
    chk("R9 slow bits", nb, 8);
    chk("R9 slow word", int'(w), 8'h6B);

    // R9 fast line: half-bits of 7 ticks
    run_frame(4'd3, 2'd3, 1'b0, 3, 8'hD2, 14, f, nb, w, e);
    chk("R9 fast found", f, 1);
    chk("R9 fast bits", nb, 8);
    chk("R9 fast word", int'(w), 8'hD2);

    // R7 violation after two preamble ones, then one bit short of the length
    hv = '0;
    nh = 0;
    for (int i = 0; i < 2; i++) begin hv[nh] = 1'b1; hv[nh+1] = 1'b0; nh += 2; end
    hv[nh] = 1'b1; hv[nh+1] = 1'b1; nh += 2;
    for (int i = 0; i < 3; i++) begin hv[nh] = 1'b1; hv[nh+1] = 1'b0; nh += 2; end
    for (int i = 0; i < 8; i++) begin hv[nh] = 1'b0; hv[nh+1] = 1'b1; nh += 2; end
    run_halves(4'd4, 2'd0, 1'b0, hv, nh, HALF_NOM, f, nb, w, e);
    chk("R7 restart no found", f, 0);
    chk("R7 restart no bits", nb, 0);
    chk("R7 error pulses", e, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule